// File: doc/BRIEF.md
# Load Lane Alignment and Store Lane Steering

This block sits between a 32-bit load/store pipeline and its data memory. On the load side it receives the word that came back from an aligned read, the two low bits of the original byte address and a load kind. From these it forms the value that goes into the destination register. Misaligned accesses never fault. A word load at a non-zero offset comes back rotated. A halfword load at an odd offset also comes back rotated. A signed halfword load at an odd offset falls back to a signed byte load, which is then rotated.

On the store side the same two address bits and a store size are used. The register operand is copied into every lane of the bus, and a byte-enable mask selects the lanes the memory must write. Lanes are numbered little-endian: lane n holds bits [8n+7:8n].

Both paths are combinational. When `REG_OUT` is set, all outputs pass through a register with a single-cycle latency. That register clears on an active-low reset.

Top module: `ldst_lane_align`

## Requirements
- R1: Load kind 0 (word) returns `rd_word` rotated right by 8 × `addr_lo` bits.
- R2: Load kind 1 (unsigned byte) returns lane `addr_lo` of `rd_word`, zero-extended to 32 bits.
- R3: Load kind 3 (signed byte) returns lane `addr_lo` of `rd_word`, sign-extended from its bit 7.
- R4: Load kind 2 (unsigned halfword) forms a 32-bit value from the halfword chosen by `addr_lo[1]` (upper half when set), zero-extended. That value is rotated right by 8 × `addr_lo[0]`, so an odd offset puts the halfword's low byte in bits [31:24].
- R5: Load kind 4 (signed halfword) at an even offset returns the halfword chosen by `addr_lo[1]`, sign-extended from its bit 15.
- R6: Load kind 4 at an odd offset takes the single lane `addr_lo` and sign-extends it from bit 7. The result is rotated right by 8: bits [31:24] hold the byte and bits [23:0] are copies of its bit 7.
- R7: Load kinds 5, 6 and 7 return zero.
- R8: Store data is the low byte of `st_src` copied into all four lanes for size 0 (byte). It is the low halfword copied into both halves for size 1 (halfword), and `st_src` unchanged for size 2 (word).
- R9: The store mask is `1 << addr_lo` for bytes. For halfwords it is 4'b0011 when `addr_lo[1]` is 0 and 4'b1100 when it is 1. For words it is 4'b1111.
- R10: Store size 3 drives zero mask and zero store data.
- R11: With `REG_OUT` = 1 every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| ld_kind | input | 3 | Load kind code: 0 word, 1 unsigned byte, 2 unsigned halfword, 3 signed byte, 4 signed halfword |
| rd_word | input | 32 | Word returned by the aligned memory read |
| addr_lo | input | 2 | Low two bits of the access byte address |
| st_size | input | 2 | Store size: 0 byte, 1 halfword, 2 word, 3 none |
| st_src | input | 32 | Register operand to be stored |
| ld_value | output | 32 | Aligned and extended load result |
| st_word | output | 32 | Lane-replicated store data |
| st_mask | output | 4 | Store byte enables, bit n for lane n |

## Verification
Load alignment and store steering share `addr_lo`, and both produce a result in every cycle. Because of this, a fault in the shared offset decoding can damage one path while the other still looks correct. Each vector therefore drives a load kind and a store size together, under the same offset and with unrelated data. The bench compares `ld_value`, `st_word` and `st_mask` against its own byte-level model one cycle later. A mismatch on either path is reported under the requirement that covers the load kind or store size in play.

// File: rtl/ldst_lane_align.sv
module ldst_lane_align #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  ld_kind,
  input  logic [31:0] rd_word,
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  st_size,
  input  logic [31:0] st_src,
  output logic [31:0] ld_value,
  output logic [31:0] st_word,
  output logic [3:0]  st_mask
);

  localparam logic [2:0] K_WORD  = 3'd0;
  localparam logic [2:0] K_UBYTE = 3'd1;
  localparam logic [2:0] K_UHALF = 3'd2;
  localparam logic [2:0] K_SBYTE = 3'd3;
  localparam logic [2:0] K_SHALF = 3'd4;

  localparam logic [1:0] S_BYTE = 2'd0;
  localparam logic [1:0] S_HALF = 2'd1;
  localparam logic [1:0] S_WORD = 2'd2;

  function automatic logic [31:0] rot_bytes(input logic [31:0] x, input logic [1:0] n);
    logic [63:0] dbl;
    dbl = {x, x} >> {n, 3'b000};
    return dbl[31:0];
  endfunction

  logic [7:0]  lane_b;
  logic [15:0] lane_h;
  logic [31:0] ld_c, st_c;
  logic [3:0]  be_c;

  assign lane_b = rd_word[{addr_lo, 3'b000} +: 8];
  assign lane_h = addr_lo[1] ? rd_word[31:16] : rd_word[15:0];

  always_comb begin
    case (ld_kind)
      K_WORD:  ld_c = rot_bytes(rd_word, addr_lo);
      K_UBYTE: ld_c = {24'b0, lane_b};
      K_SBYTE: ld_c = {{24{lane_b[7]}}, lane_b};
      K_UHALF: ld_c = rot_bytes({16'b0, lane_h}, {1'b0, addr_lo[0]});
      K_SHALF: ld_c = addr_lo[0] ? rot_bytes({{24{lane_b[7]}}, lane_b}, 2'd1)
                                 : {{16{lane_h[15]}}, lane_h};
      default: ld_c = '0;
    endcase
  end

  always_comb begin
    case (st_size)
      S_BYTE: begin
        st_c = {4{st_src[7:0]}};
        be_c = 4'b0001 << addr_lo;
      end
      S_HALF: begin
        st_c = {2{st_src[15:0]}};
        be_c = addr_lo[1] ? 4'b1100 : 4'b0011;
      end
      S_WORD: begin
        st_c = st_src;
        be_c = 4'b1111;
      end
      default: begin
        st_c = '0;
        be_c = 4'b0000;
      end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ld_value <= '0;
          st_word  <= '0;
          st_mask  <= '0;
        end else begin
          ld_value <= ld_c;
          st_word  <= st_c;
          st_mask  <= be_c;
        end
      end

      a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ld_value == '0 && st_word == '0 && st_mask == '0));

      a_r2_ubyte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_kind) == K_UBYTE) |-> ld_value[31:8] == 24'b0);

      a_r3_sbyte_extends: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_kind) == K_SBYTE) |-> ld_value[31:8] == {24{ld_value[7]}});

      a_r5_shalf_even_extends: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_kind) == K_SHALF && !$past(addr_lo[0]))
        |-> ld_value[31:16] == {16{ld_value[15]}});

      a_r6_shalf_odd_layout: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_kind) == K_SHALF && $past(addr_lo[0]))
        |-> ld_value[23:0] == {24{ld_value[31]}});

      a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_kind) > K_SHALF) |-> ld_value == '0);

      a_r9_byte_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_size) == S_BYTE) |-> ($onehot0(st_mask) && st_mask != 4'b0));

      a_r9_half_mask_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_size) == S_HALF)
        |-> ($countones(st_mask) == 2 && st_mask[0] == st_mask[1]));

      a_r10_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_size) == 2'd3) |-> (st_mask == 4'b0 && st_word == '0));
    end else begin : g_comb
      assign ld_value = ld_c;
      assign st_word  = st_c;
      assign st_mask  = be_c;

      a_r8_word_passes: assert property (@(posedge clk) disable iff (!rst_n)
        st_size == S_WORD |-> (st_word == st_src && st_mask == 4'b1111));

      a_r2_ubyte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ld_kind == K_UBYTE |-> ld_value[31:8] == 24'b0);

      a_r3_sbyte_extends: assert property (@(posedge clk) disable iff (!rst_n)
        ld_kind == K_SBYTE |-> ld_value[31:8] == {24{ld_value[7]}});

      a_r10_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_size == 2'd3 |-> (st_mask == 4'b0 && st_word == '0));
    end
  endgenerate

endmodule

// File: tb/tb_ldst_lane_align.sv
module tb_ldst_lane_align;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ld_kind = '0;
  logic [31:0] rd_word = '0;
  logic [1:0]  addr_lo = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] st_src = '0;
  logic [31:0] ld_value, st_word;
  logic [3:0]  st_mask;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [31:0] q_ld[$];
  logic [31:0] q_sd[$];
  logic [3:0]  q_be[$];
  string       q_ltag[$];
  string       q_stag[$];

  always #2 clk = ~clk;

  ldst_lane_align #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ld_kind(ld_kind), .rd_word(rd_word),
    .addr_lo(addr_lo), .st_size(st_size), .st_src(st_src),
    .ld_value(ld_value), .st_word(st_word), .st_mask(st_mask)
  );

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [31:0] rotr_model(input logic [31:0] w, input int n);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = byte_of(w, (i + n) % 4);
    return r;
  endfunction

  function automatic logic [31:0] ld_model(input int k, input logic [31:0] w, input int a);
    int b, h;
    b = byte_of(w, a);
    h = (a >= 2) ? int'(w[31:16]) : int'(w[15:0]);
    case (k)
      0: return rotr_model(w, a);
      1: return 32'(b);
      3: return (b >= 128) ? 32'(b - 256) : 32'(b);
      2: return rotr_model(32'(h), a % 2);
      4: if (a % 2 == 0) return (h >= 32768) ? 32'(h - 65536) : 32'(h);
         else return rotr_model((b >= 128) ? 32'(b - 256) : 32'(b), 1);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string ltag(input int k, input int a);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R3";
      4: return (a % 2) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input int k, input logic [31:0] w, input int a, input int s, input logic [31:0] src);
    logic [31:0] sd;
    logic [3:0]  be;
    ld_kind = 3'(k);
    rd_word = w;
    addr_lo = 2'(a);
    st_size = 2'(s);
    st_src  = src;
    case (s)
      0: begin sd = {src[7:0], src[7:0], src[7:0], src[7:0]}; be = 4'(1 << a); end
      1: begin sd = {src[15:0], src[15:0]}; be = (a >= 2) ? 4'hC : 4'h3; end
      2: begin sd = src; be = 4'hF; end
      default: begin sd = 32'd0; be = 4'h0; end
    endcase
    q_ld.push_back(ld_model(k, w, a));
    q_sd.push_back(sd);
    q_be.push_back(be);
    q_ltag.push_back(ltag(k, a));
    q_stag.push_back(s == 3 ? "R10" : (s == 2 ? "R8" : "R9"));
  endtask

  task automatic check_one();
    logic [31:0] el, es;
    logic [3:0]  eb;
    string       lt, st;
    el = q_ld.pop_front();
    es = q_sd.pop_front();
    eb = q_be.pop_front();
    lt = q_ltag.pop_front();
    st = q_stag.pop_front();
    vectors++;
    if (ld_value !== el) begin
      misses++;
      $display("FAIL %s ld_value actual=%h expected=%h", lt, ld_value, el);
    end
    if (st_word !== es) begin
      misses++;
      $display("FAIL %s st_word actual=%h expected=%h", (st == "R9") ? "R8" : st, st_word, es);
    end
    if (st_mask !== eb) begin
      misses++;
      $display("FAIL %s st_mask actual=%b expected=%b", st, st_mask, eb);
    end
  endtask

  task automatic step(input int k, input logic [31:0] w, input int a, input int s, input logic [31:0] src);
    @(negedge clk);
    if (q_ld.size() != 0) check_one();
    apply(k, w, a, s, src);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        vectors++;
        if (ld_value !== 32'd0 || st_word !== 32'd0 || st_mask !== 4'd0) begin
          misses++;
          $display("FAIL R11 reset outputs actual=%h/%h/%b expected=0", ld_value, st_word, st_mask);
        end
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++)
          for (int k = 0; k < 8; k++)
            step(k, 32'h8E7F_01C3, a, (k + a) % 4, 32'hA5B6_C7D8);
        for (int a = 0; a < 4; a++) begin
          step(4, 32'h7F80_807F, a, 0, 32'h0000_00FF);
          step(2, 32'hFFFF_0001, a, 1, 32'h1234_8001);
          step(0, 32'h4433_2211, a, 2, 32'hDEAD_BEEF);
        end
        for (int i = 0; i < 3000; i++)
          step(int'($urandom_range(0, 7)), $urandom, int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), $urandom);
        @(negedge clk);
        check_one();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        vectors++;
        if (ld_value !== 32'd0 || st_word !== 32'd0 || st_mask !== 4'd0) begin
          misses++;
          $display("FAIL R11 mid-run reset actual=%h/%h/%b expected=0", ld_value, st_word, st_mask);
        end
        done = 1'b1;
      end
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          misses++;
          $display("FAIL R11 watchdog expired actual=hung expected=finished");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule